// File: doc/BRIEF.md
# Video Control Register Slave (I2C, write-only)

This block is a write-only I2C target that keeps eight 8-bit control words for a three-channel video path: a shared contrast gain, a shared brightness offset, one gain per channel, an output DC level, an on-screen-display gain and a control byte for back-porch clamping and overlay options. Each word drives its own parallel output, so the downstream analog or digital video logic always sees the current settings.

SCL and SDA are sampled with a fast system clock. Each line passes through a synchronizer and a glitch filter. START and STOP conditions are then found from the filtered lines. The first byte after START carries the 7-bit target address and the direction bit. The next byte selects a register. Each byte after that is written to the selected register, and the selection then advances by one. The target acknowledges by pulling SDA low through an open-drain enable. Reads are never granted.

Top module: `vidctl_i2c_slave`

## Requirements
- R1: After reset the outputs hold contrast 0xB4, brightness 0xB4, the three channel gains 0xB4, DC level 0x08, display gain 0x08 and control byte 0x04.
- R2: A byte of 0xDC after START (7-bit address 0x6E, direction bit LSB = 0 for write) is acknowledged. The target holds SDA low (sda_oe = 1) through the ninth SCL high phase. The two bytes that follow are also acknowledged.
- R3: An address byte of 0xDD (a read request) is not acknowledged, and no register changes until the next START.
- R4: An address byte with any other 7-bit address is not acknowledged and changes no register.
- R5: Sub-address 1 selects contrast, 2 brightness, 3 to 5 the channel gains A to C, 6 the DC level, 7 the display gain and 8 the control byte. After each data byte the sub-address advances by one, so consecutive bytes fill consecutive registers.
- R6: Data bytes whose sub-address is 0x00 or above 0x08 are acknowledged but stored nowhere.
- R7: The DC level and display gain keep only the low nibble of a written byte. Bits 7:4 of those two outputs always read zero.
- R8: A DC level write whose low nibble is 0, 1 or 2 stores 0x03 instead. The DC level output is never below 0x03.
- R9: A START inside a byte abandons that byte, and a new address phase begins.
- R10: A STOP inside a byte abandons the transfer without any write. Registers change only on a completed data byte.
- R11: A low pulse on SCL that lasts fewer than three sample cycles is not treated as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| ctl_contrast | output | 8 | Shared contrast gain |
| ctl_bright | output | 8 | Shared brightness offset |
| ctl_gain_a | output | 8 | Channel A gain |
| ctl_gain_b | output | 8 | Channel B gain |
| ctl_gain_c | output | 8 | Channel C gain |
| ctl_dc_level | output | 8 | Output DC level, low nibble, floor 0x03 |
| ctl_osd_gain | output | 8 | Display overlay gain, low nibble |
| ctl_misc | output | 8 | Back-porch and overlay control byte |

## Verification
Each line reaches the byte engine about six clocks after the pin changes: two synchronizer stages, three filter samples and the edge register. The acknowledge is raised one clock after the filtered falling edge of the eighth SCL pulse. A register output changes two clocks after that same edge. The bench holds every SCL phase for twelve clocks, samples the acknowledge in the middle of the ninth high phase and reads the registers only after STOP. Every result is therefore settled before it is compared. Sampling is done on the falling clock edge.

// File: rtl/vidctl_i2c_pkg.sv
// Shared constants, phase type and register shaping rules for the
// video control I2C slave. Assumes sub-addresses start at 1.
package vidctl_i2c_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_REGS  = 8;
    localparam int DC_SUB    = 6;
    localparam int OSD_SUB   = 7;
    localparam int DC_FLOOR  = 3;

    typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_SUB, PH_DATA} phase_e;

    // Power-on value of the register at sub-address sub.
    function automatic logic [REG_W-1:0] por_value(input int sub);
        if (sub <= 5)                         return 8'hB4;
        else if (sub == DC_SUB || sub == OSD_SUB) return 8'h08;
        else                                  return 8'h04;
    endfunction

    // Value actually stored for a write of d to sub-address sub.
    function automatic logic [REG_W-1:0] shape_value(input int sub, input logic [REG_W-1:0] d);
        logic [REG_W-1:0] v;
        v = d;
        if (sub == DC_SUB || sub == OSD_SUB) v = {4'h0, d[3:0]};
        if (sub == DC_SUB && v < REG_W'(DC_FLOOR)) v = REG_W'(DC_FLOOR);
        return v;
    endfunction
endpackage

// File: rtl/vidctl_line_filter.sv
// Synchronizes one open-drain bus line into clk and removes pulses
// shorter than FILT_LEN samples. Idle (reset) level is high.
module vidctl_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;

    // Synchronizer chain, sample history and filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q)       line_o <= 1'b1;
            else if (~|hist_q) line_o <= 1'b0;
        end
    end
endmodule

// File: rtl/vidctl_i2c_engine.sv
// Byte engine: finds START/STOP and SCL edges on filtered lines, shifts
// bytes in MSB first, checks the address, latches the sub-address and
// issues one write strobe per data byte. Never stretches SCL.
module vidctl_i2c_engine
    import vidctl_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_f,
    input  logic             sda_f,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_sub,
    output logic [REG_W-1:0] wr_data
);
    logic             scl_q, sda_q, ack_q;
    logic [3:0]       bit_cnt;
    logic [REG_W-1:0] shreg, sub_q;
    phase_e           phase;
    logic             scl_rise, scl_fall, start_ev, stop_ev, sub_ok;

    // Bus events from the filtered lines and their previous values.
    always_comb begin
        scl_rise = scl_f & ~scl_q;
        scl_fall = ~scl_f & scl_q;
        start_ev = scl_f & scl_q & sda_q & ~sda_f;
        stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
        sub_ok   = (sub_q != '0) && (sub_q <= REG_W'(NUM_REGS));
    end

    assign sda_oe = ack_q;

    // Transfer state: phase, bit count, shift register, acknowledge, strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1; sda_q <= 1'b1; ack_q <= 1'b0;
            bit_cnt <= '0; shreg <= '0; sub_q <= '0;
            phase <= PH_IDLE; wr_en <= 1'b0; wr_sub <= '0; wr_data <= '0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            wr_en <= 1'b0;
            if (start_ev) begin
                phase <= PH_ADDR; bit_cnt <= '0; ack_q <= 1'b0;
            end else if (stop_ev) begin
                phase <= PH_IDLE; bit_cnt <= '0; ack_q <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise && !ack_q && bit_cnt < 4'd8) begin
                    shreg   <= {shreg[REG_W-2:0], sda_f};
                    bit_cnt <= bit_cnt + 4'd1;
                end else if (scl_fall) begin
                    if (ack_q) begin
                        ack_q <= 1'b0; bit_cnt <= '0;
                    end else if (bit_cnt == 4'd8) begin
                        case (phase)
                            PH_ADDR: begin
                                if (shreg == {DEV_ADDR, 1'b0}) begin
                                    ack_q <= 1'b1; phase <= PH_SUB;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            PH_SUB: begin
                                ack_q <= 1'b1; sub_q <= shreg; phase <= PH_DATA;
                            end
                            default: begin
                                ack_q   <= 1'b1;
                                wr_en   <= sub_ok;
                                wr_sub  <= sub_q;
                                wr_data <= shreg;
                                sub_q   <= sub_q + 1'b1;
                            end
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/vidctl_regfile.sv
// Register file: one word per sub-address 1..NUM_REGS, loaded with its
// power-on value at reset and written through shape_value().
module vidctl_regfile
    import vidctl_i2c_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [REG_W-1:0]          wr_sub,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [REG_W-1:0] word_q;
        // One control word: reset value or shaped write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= por_value(i + 1);
            else if (wr_en && wr_sub == REG_W'(i + 1))
                word_q <= shape_value(i + 1, wr_data);
        end
        assign regs_flat[i*REG_W +: REG_W] = word_q;
    end
endmodule

// File: rtl/vidctl_i2c_slave.sv
// Top: filters both bus lines, runs the byte engine and holds the eight
// control words on parallel outputs. SDA is driven only low via sda_oe.
module vidctl_i2c_slave
    import vidctl_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h6E,
    parameter int          SYNC_STAGES = 2,
    parameter int          FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] ctl_contrast,
    output logic [7:0] ctl_bright,
    output logic [7:0] ctl_gain_a,
    output logic [7:0] ctl_gain_b,
    output logic [7:0] ctl_gain_c,
    output logic [7:0] ctl_dc_level,
    output logic [7:0] ctl_osd_gain,
    output logic [7:0] ctl_misc
);
    logic [1:0]                lines_raw, lines_flt;
    logic                      scl_flt, sda_flt, wr_en;
    logic [REG_W-1:0]          wr_sub, wr_data;
    logic [NUM_REGS*REG_W-1:0] regs_flat;

    assign lines_raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        vidctl_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .line_i(lines_raw[g]), .line_o(lines_flt[g]));
    end

    assign scl_flt = lines_flt[0];
    assign sda_flt = lines_flt[1];

    vidctl_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_flt), .sda_f(sda_flt),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_sub(wr_sub), .wr_data(wr_data));

    vidctl_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sub(wr_sub),
        .wr_data(wr_data), .regs_flat(regs_flat));

    assign ctl_contrast = regs_flat[0*8 +: 8];
    assign ctl_bright   = regs_flat[1*8 +: 8];
    assign ctl_gain_a   = regs_flat[2*8 +: 8];
    assign ctl_gain_b   = regs_flat[3*8 +: 8];
    assign ctl_gain_c   = regs_flat[4*8 +: 8];
    assign ctl_dc_level = regs_flat[5*8 +: 8];
    assign ctl_osd_gain = regs_flat[6*8 +: 8];
    assign ctl_misc     = regs_flat[7*8 +: 8];
endmodule

// File: rtl/vidctl_i2c_chk.sv
// Property checker for vidctl_i2c_slave, attached by bind below.
module vidctl_i2c_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_flt,
    input logic       wr_en,
    input logic [7:0] dc_level,
    input logic [7:0] osd_gain,
    input logic [7:0] contrast
);
    // R8: DC level never below its floor code.
    a_r8_dc_floor: assert property (@(posedge clk) disable iff (!rst_n)
        dc_level >= 8'h03);
    // R7: upper nibble of the two narrow registers stays zero.
    a_r7_upper_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_level[7:4] == 4'h0) && (osd_gain[7:4] == 4'h0));
    // R2: acknowledge starts only while the filtered clock is low.
    a_r2_ack_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_flt);
    // R2: acknowledge is released only while the filtered clock is low.
    a_r2_ack_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_flt);
    // R10: a register moves only after a write strobe.
    a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(contrast));
endmodule

bind vidctl_i2c_slave vidctl_i2c_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_flt(scl_flt),
    .wr_en(wr_en), .dc_level(ctl_dc_level), .osd_gain(ctl_osd_gain),
    .contrast(ctl_contrast));

// File: tb/vidctl_i2c_slave_tb.sv
module vidctl_i2c_slave_tb;
    localparam int Q = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic glitch_en = 1'b0;
    logic sda_line, sda_oe;
    logic [7:0] o_con, o_bri, o_ga, o_gb, o_gc, o_dc, o_osd, o_misc;
    logic [7:0] model [1:8];
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    vidctl_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .ctl_contrast(o_con), .ctl_bright(o_bri), .ctl_gain_a(o_ga), .ctl_gain_b(o_gb),
        .ctl_gain_c(o_gc), .ctl_dc_level(o_dc), .ctl_osd_gain(o_osd), .ctl_misc(o_misc));

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] get_reg(input int s);
        case (s)
            1: return o_con;  2: return o_bri; 3: return o_ga;  4: return o_gb;
            5: return o_gc;   6: return o_dc;  7: return o_osd; default: return o_misc;
        endcase
    endfunction

    // Stored value per requirements R7 and R8.
    function automatic logic [7:0] expect_store(input int s, input logic [7:0] d);
        logic [7:0] v;
        v = d;
        if (s == 6 || s == 7) v = d & 8'h0F;
        if (s == 6 && v < 8'h03) v = 8'h03;
        return v;
    endfunction

    task automatic check_all(input string req);
        for (int s = 1; s <= 8; s++) check(req, get_reg(s), model[s]);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wt(Q); m_scl = 1'b1; wt(Q / 2);
        if (glitch_en) begin
            m_scl = 1'b0; wt(2); m_scl = 1'b1; wt(Q / 2 - 2);
        end else wt(Q / 2);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q / 2);
        ack = ~sda_line;
        wt(Q / 2); m_scl = 1'b0; wt(Q);
    endtask

    // Full write transfer with ack checks and model update.
    task automatic xfer(input logic [7:0] abyte, input logic [7:0] sub, input int n,
                        input logic [31:0] dw);
        logic ack;
        logic [7:0] s;
        bus_start;
        send_byte(abyte, ack);
        if (abyte == 8'hDC) check("R2 addr ack", {7'd0, ack}, 8'd1);
        else if (abyte == 8'hDD) check("R3 read nack", {7'd0, ack}, 8'd0);
        else check("R4 foreign nack", {7'd0, ack}, 8'd0);
        if (abyte == 8'hDC) begin
            send_byte(sub, ack);
            check("R2 sub ack", {7'd0, ack}, 8'd1);
            s = sub;
            for (int k = 0; k < n; k++) begin
                send_byte(dw[8*k +: 8], ack);
                check("R6 data ack", {7'd0, ack}, 8'd1);
                if (s >= 8'd1 && s <= 8'd8) model[s] = expect_store(int'(s), dw[8*k +: 8]);
                s = s + 8'd1;
            end
        end
        bus_stop;
        wt(Q);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        logic ack;
        seed_v = $urandom(32'd1234);
        for (int s = 1; s <= 8; s++) model[s] = (s <= 5) ? 8'hB4 : ((s <= 7) ? 8'h08 : 8'h04);
        wt(5); rst_n = 1'b1; wt(5);
        check_all("R1");
        check("R1 sda_oe", {7'd0, sda_oe}, 8'd0);

        xfer(8'hDC, 8'd1, 1, 32'h0000_005A);  check_all("R2");
        xfer(8'hDD, 8'd2, 1, 32'h0000_0011);  check_all("R3");
        xfer(8'hA0, 8'd2, 1, 32'h0000_0022);  check_all("R4");
        xfer(8'hDC, 8'd3, 3, 32'h0033_2211);  check_all("R5");
        xfer(8'hDC, 8'd8, 3, 32'h0077_6655);  check_all("R6");
        xfer(8'hDC, 8'd0, 1, 32'h0000_0099);  check_all("R6");
        xfer(8'hDC, 8'd6, 2, 32'h0000_A5F9);  check_all("R7");
        xfer(8'hDC, 8'd6, 1, 32'h0000_0001);  check_all("R8");
        xfer(8'hDC, 8'd6, 1, 32'h0000_0012);  check_all("R8");
        xfer(8'hDC, 8'd6, 1, 32'h0000_0003);  check_all("R8");

        // R9: five address bits, then a fresh START.
        bus_start;
        for (int i = 7; i >= 3; i--) send_bit(1'b1);
        xfer(8'hDC, 8'd2, 1, 32'h0000_003C);  check_all("R9");

        // R10: STOP after four data bits, no write.
        bus_start;
        send_byte(8'hDC, ack); check("R10 addr ack", {7'd0, ack}, 8'd1);
        send_byte(8'h01, ack); check("R10 sub ack", {7'd0, ack}, 8'd1);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop; wt(Q);
        check_all("R10");

        // R11: short SCL low pulses inside every high phase.
        glitch_en = 1'b1;
        xfer(8'hDC, 8'd4, 2, 32'h0000_C3E7);  check_all("R11");
        glitch_en = 1'b0;

        for (int it = 0; it < 40; it++) begin
            logic [7:0] ab;
            ab = ($urandom % 6 == 0) ? 8'($urandom) : 8'hDC;
            if (ab == 8'hDC) xfer(ab, 8'($urandom % 11), 1 + int'($urandom % 4), $urandom);
            else xfer(ab, 8'd1, 1, $urandom);
            check_all("R5");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule